// File: doc/BRIEF.md
# Downstream I2C Bus Activity Sensor

This block watches the two lines of a shared downstream I2C segment and keeps a single idle/busy verdict for it. A START condition (data line falling while the clock line is high) marks the segment busy; a STOP condition (data line rising while the clock line is high) marks it idle again. Each detected condition also produces a one-cycle pulse, so power-up sequencing logic that must wait for an idle bus can key off the STOP pulse directly. Both bus lines are sampled asynchronously and pass through a synchronizer chain inside the block before any edge is decoded.

The second job of the block is to catch unsafe handovers. Whenever the upstream channel selection changes while the segment is busy and the hardware bus-recovery sequence is switched off, a sticky interrupt flag is raised. It tells the master that has just been granted the segment that a transfer was cut in half and that it has to clean up the bus itself. The flag has its own mask and is cleared by a dedicated strobe. Nothing beyond START and STOP is decoded.

Top module: `bus_traffic_sensor`

## Requirements
- R1: While and directly after reset (rst_n low at a clock edge), bus_busy, start_pulse, stop_pulse and switch_irq are all 0; the bus is taken as idle until a START is seen.
- R2: A START (sda_in going 1 to 0 while scl_in stays 1) sets bus_busy to 1 and raises start_pulse for exactly one clock cycle.
- R3: A STOP (sda_in going 0 to 1 while scl_in stays 1) clears bus_busy to 0 and raises stop_pulse for exactly one clock cycle; the pulse is produced even when the bus was already idle.
- R4: Changes of sda_in made while scl_in is 0 (ordinary data bits) change neither bus_busy nor either pulse output.
- R5: A repeated START seen while the bus is busy keeps bus_busy at 1 and still raises start_pulse once.
- R6: With the default SYNC_STAGES of 2, a bus condition applied before a clock edge becomes visible on bus_busy and the pulse outputs after the third rising edge (SYNC_STAGES + 1 edges), not earlier.
- R7: If chan_sel differs from its value in the previous cycle while bus_busy is 1, recov_en is 0 and irq_mask is 0, switch_irq is 1 after the next rising edge.
- R8: While recov_en is 1, a channel change never raises switch_irq, even on a busy bus.
- R9: A channel change while bus_busy is 0 does not raise switch_irq.
- R10: While irq_mask is 1, switch_irq is 0; a channel change made while masked is not remembered, whereas a flag already set before masking reappears when the mask drops.
- R11: Once set, switch_irq stays 1 until irq_clr is seen high at a rising edge, after which it is 0; if a new trigger and irq_clr arrive in the same cycle, the trigger wins and the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, much faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Downstream clock line level, asynchronous |
| sda_in | input | 1 | Downstream data line level, asynchronous |
| chan_sel | input | CH_W (2) | Currently selected upstream channel code |
| recov_en | input | 1 | 1 when automatic bus recovery is in use |
| irq_mask | input | 1 | 1 suppresses the switch interrupt |
| irq_clr | input | 1 | Clear strobe for the sticky switch interrupt |
| bus_busy | output | 1 | 1 between a START and the next STOP |
| start_pulse | output | 1 | One-cycle pulse per detected START |
| stop_pulse | output | 1 | One-cycle pulse per detected STOP |
| switch_irq | output | 1 | Sticky flag: channel changed on a busy bus |

## Verification
A wrong busy state is the dangerous fault here: it shows up either as a switch during a transfer that raises no interrupt, or as an interrupt on a handover made while the segment was idle, and it is observable on bus_busy within SYNC_STAGES + 1 cycles of the bus condition that should have set or cleared it. Misdecoded edges show up as spurious or missing pulses, so the bench counts pulses over whole bus sequences, including data bits clocked with the clock line low. A flag that fails to hold, clear, or respect the mask is visible on switch_irq one cycle after the channel change or the clear strobe.

// File: rtl/bts_pkg.sv
// Package: shared types and constants for the bus traffic sensor.
// Assumes: included first in compile order.
package bts_pkg;

    // Idle/busy verdict for the downstream segment.
    typedef enum logic {
        SEG_IDLE = 1'b0,
        SEG_BUSY = 1'b1
    } seg_state_t;

    // Released bus lines read as high.
    localparam logic LINE_RELEASED = 1'b1;

endpackage

// File: rtl/bts_line_sync.sv
// Module: bts_line_sync
// Brings one asynchronous bus line into the clock domain through a chain
// of STAGES flops. Resets to the released (high) level so no false edge is
// seen when reset lifts on an idle bus. Assumes STAGES >= 2.
module bts_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_out
);
    import bts_pkg::*;

    logic [STAGES-1:0] chain;

    // Shift the raw level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{LINE_RELEASED}};
        end else begin
            chain <= {chain[STAGES-2:0], line_in};
        end
    end

    assign line_out = chain[STAGES-1];

endmodule

// File: rtl/bts_cond_detect.sv
// Module: bts_cond_detect
// Decodes START and STOP from synchronized clock/data lines and keeps the
// idle/busy state. A condition counts only if the clock line was high on
// both the previous and the current sample, so data-line moves that
// coincide with a clock edge are ignored. Pulses and state are registered.
module bts_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic busy,
    output logic start_p,
    output logic stop_p
);
    import bts_pkg::*;

    logic       scl_q;
    logic       sda_q;
    logic       start_hit;
    logic       stop_hit;
    seg_state_t state;
    seg_state_t state_nxt;

    // Hold the previous synchronized sample of both lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= LINE_RELEASED;
            sda_q <= LINE_RELEASED;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Recognize data-line edges with the clock line steady high.
    always_comb begin
        start_hit = scl_q && scl_s && sda_q && !sda_s;
        stop_hit  = scl_q && scl_s && !sda_q && sda_s;
    end

    // Choose the next segment state from the decoded conditions.
    always_comb begin
        state_nxt = state;
        if (start_hit) begin
            state_nxt = SEG_BUSY;
        end else if (stop_hit) begin
            state_nxt = SEG_IDLE;
        end
    end

    // Register the state and the one-cycle condition pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SEG_IDLE;
            start_p <= 1'b0;
            stop_p  <= 1'b0;
        end else begin
            state   <= state_nxt;
            start_p <= start_hit;
            stop_p  <= stop_hit;
        end
    end

    assign busy = (state == SEG_BUSY);

    // R2: the two condition pulses are never high together.
    p_pulses_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_p && stop_p));

    // R2: a START pulse coincides with a busy segment.
    p_start_marks_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_p |-> busy);

    // R2: busy only ever rises together with a START pulse.
    p_busy_rise_needs_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> start_p);

    // R2: START pulse lasts a single cycle.
    p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_p |=> !start_p);

    // R3: a STOP pulse coincides with an idle segment.
    p_stop_marks_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p |-> !busy);

    // R3: STOP pulse lasts a single cycle.
    p_stop_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p |=> !stop_p);

endmodule

// File: rtl/bts_switch_guard.sv
// Module: bts_switch_guard
// Watches the channel selection and raises a sticky flag when it changes
// while the segment is busy and automatic recovery is off. The mask both
// blocks new triggers and hides a pending flag. A trigger in the same
// cycle as the clear strobe wins. Assumes chan_sel is synchronous to clk.
module bts_switch_guard #(
    parameter int CH_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CH_W-1:0] chan_sel,
    input  logic            busy,
    input  logic            recov_en,
    input  logic            irq_mask,
    input  logic            irq_clr,
    output logic            irq
);
    logic [CH_W-1:0] chan_q;
    logic            chan_moved;
    logic            trig;
    logic            flag;

    // Remember last cycle's selection to detect a change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q <= '0;
        end else begin
            chan_q <= chan_sel;
        end
    end

    // Qualify a selection change with busy, recovery mode and mask.
    always_comb begin
        chan_moved = (chan_sel != chan_q);
        trig       = chan_moved && busy && !recov_en && !irq_mask;
    end

    // Sticky flag: trigger sets, clear strobe clears, trigger wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (trig) begin
            flag <= 1'b1;
        end else if (irq_clr) begin
            flag <= 1'b0;
        end
    end

    assign irq = flag && !irq_mask;

    // R10: a masked interrupt is never visible.
    p_mask_silences_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mask |-> !irq);

    // R11: without a clear the flag holds.
    p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !irq_clr) |=> flag);

    // R11: a clear with no concurrent trigger empties the flag.
    p_clear_works_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !(chan_sel != chan_q)) |=> !flag);

    // R8: with recovery enabled an empty flag stays empty.
    p_recov_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (recov_en && !flag) |=> !flag);

    // R9: an idle segment never sets an empty flag.
    p_idle_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !flag) |=> !flag);

endmodule

// File: rtl/bus_traffic_sensor.sv
// Module: bus_traffic_sensor (top)
// Synchronizes the downstream clock and data lines, decodes START/STOP
// into an idle/busy verdict with condition pulses, and flags channel
// switches made on a busy segment when automatic recovery is off.
// Assumes clk runs well above the bus clock so each bus level lasts
// several samples.
module bus_traffic_sensor #(
    parameter int SYNC_STAGES = 2,
    parameter int CH_W        = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_in,
    input  logic            sda_in,
    input  logic [CH_W-1:0] chan_sel,
    input  logic            recov_en,
    input  logic            irq_mask,
    input  logic            irq_clr,
    output logic            bus_busy,
    output logic            start_pulse,
    output logic            stop_pulse,
    output logic            switch_irq
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] sync_lines;

    assign raw_lines = {sda_in, scl_in};

    // One synchronizer per bus line.
    for (genvar g = 0; g < N_LINES; g++) begin : g_sync
        bts_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .line_in  (raw_lines[g]),
            .line_out (sync_lines[g])
        );
    end

    bts_cond_detect u_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_s   (sync_lines[0]),
        .sda_s   (sync_lines[1]),
        .busy    (bus_busy),
        .start_p (start_pulse),
        .stop_p  (stop_pulse)
    );

    bts_switch_guard #(.CH_W(CH_W)) u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .chan_sel (chan_sel),
        .busy     (bus_busy),
        .recov_en (recov_en),
        .irq_mask (irq_mask),
        .irq_clr  (irq_clr),
        .irq      (switch_irq)
    );

    // R1: the first cycle out of reset shows a quiet, idle block.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !$past(rst_n) |-> !(bus_busy || start_pulse || stop_pulse || switch_irq));

endmodule

// File: tb/tb_bus_traffic_sensor.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_bus_traffic_sensor;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_in = 1'b1;
    logic       sda_in = 1'b1;
    logic [1:0] chan_sel = 2'd0;
    logic       recov_en = 1'b0;
    logic       irq_mask = 1'b0;
    logic       irq_clr = 1'b0;
    logic       bus_busy, start_pulse, stop_pulse, switch_irq;

    int n_cmp = 0;
    int n_bad = 0;
    int n_start = 0;
    int n_stop = 0;
    bit finished = 0;

    bus_traffic_sensor dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .chan_sel(chan_sel), .recov_en(recov_en), .irq_mask(irq_mask),
        .irq_clr(irq_clr), .bus_busy(bus_busy), .start_pulse(start_pulse),
        .stop_pulse(stop_pulse), .switch_irq(switch_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Count pulses away from the active edge.
    always @(negedge clk) begin
        if (start_pulse) n_start++;
        if (stop_pulse)  n_stop++;
    end

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic lines(input logic scl, input logic sda);
        @(negedge clk);
        scl_in = scl;
        sda_in = sda;
        repeat (SETTLE) @(negedge clk);
    endtask

    task automatic clear_counts();
        n_start = 0;
        n_stop = 0;
    endtask

    task automatic do_start();
        lines(1'b0, 1'b1);
        lines(1'b1, 1'b1);
        lines(1'b1, 1'b0);
    endtask

    task automatic do_stop();
        lines(1'b0, 1'b0);
        lines(1'b1, 1'b0);
        lines(1'b1, 1'b1);
    endtask

    task automatic move_chan(input logic clr);
        @(negedge clk);
        chan_sel = chan_sel + 2'd1;
        irq_clr = clr;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1 busy", bus_busy, 0);
        check("R1 start_pulse", start_pulse, 0);
        check("R1 stop_pulse", stop_pulse, 0);
        check("R1 switch_irq", switch_irq, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 busy after release", bus_busy, 0);
    endtask

    task automatic t_start_latency();
        clear_counts();
        @(negedge clk);
        sda_in = 1'b0;
        repeat (2) @(negedge clk);
        check("R6 busy not before third edge", bus_busy, 0);
        @(negedge clk);
        check("R6 busy at third edge", bus_busy, 1);
        check("R6 start_pulse at third edge", start_pulse, 1);
        repeat (SETTLE) @(negedge clk);
        check("R2 busy held", bus_busy, 1);
        check("R2 one start pulse", n_start, 1);
        check("R2 no stop pulse", n_stop, 0);
    endtask

    task automatic t_data_bits();
        clear_counts();
        lines(1'b0, 1'b0);
        lines(1'b0, 1'b1);
        lines(1'b1, 1'b1);
        lines(1'b0, 1'b1);
        lines(1'b0, 1'b0);
        lines(1'b1, 1'b0);
        lines(1'b0, 1'b0);
        lines(1'b0, 1'b1);
        check("R4 busy unchanged", bus_busy, 1);
        check("R4 no start pulse", n_start, 0);
        check("R4 no stop pulse", n_stop, 0);
    endtask

    task automatic t_restart();
        clear_counts();
        do_start();
        check("R5 busy kept", bus_busy, 1);
        check("R5 one start pulse", n_start, 1);
        check("R5 no stop pulse", n_stop, 0);
    endtask

    task automatic t_stop();
        clear_counts();
        do_stop();
        check("R3 busy cleared", bus_busy, 0);
        check("R3 one stop pulse", n_stop, 1);
        clear_counts();
        do_stop();
        check("R3 stop on idle bus pulses", n_stop, 1);
        check("R3 idle bus stays idle", bus_busy, 0);
    endtask

    task automatic t_switch_idle();
        move_chan(1'b0);
        check("R9 idle switch no irq", switch_irq, 0);
        repeat (2) @(negedge clk);
        check("R9 idle switch no irq later", switch_irq, 0);
    endtask

    task automatic t_switch_busy();
        do_start();
        move_chan(1'b0);
        check("R7 irq one edge after change", switch_irq, 1);
        repeat (5) @(negedge clk);
        check("R11 irq sticky", switch_irq, 1);
        pulse_clr();
        check("R11 cleared by strobe", switch_irq, 0);
    endtask

    task automatic t_recovery();
        recov_en = 1'b1;
        move_chan(1'b0);
        check("R8 recovery on no irq", switch_irq, 0);
        recov_en = 1'b0;
        @(negedge clk);
        check("R8 still no irq", switch_irq, 0);
    endtask

    task automatic t_mask();
        irq_mask = 1'b1;
        move_chan(1'b0);
        check("R10 masked no irq", switch_irq, 0);
        irq_mask = 1'b0;
        @(negedge clk);
        check("R10 masked change not remembered", switch_irq, 0);
        move_chan(1'b0);
        check("R10 unmasked irq set", switch_irq, 1);
        irq_mask = 1'b1;
        @(negedge clk);
        check("R10 mask hides pending flag", switch_irq, 0);
        irq_mask = 1'b0;
        @(negedge clk);
        check("R10 pending flag reappears", switch_irq, 1);
        pulse_clr();
        check("R11 clear after mask test", switch_irq, 0);
    endtask

    task automatic t_set_beats_clear();
        move_chan(1'b1);
        check("R11 trigger wins over clear", switch_irq, 1);
        pulse_clr();
        check("R11 later clear works", switch_irq, 0);
        do_stop();
        check("R3 final stop idles bus", bus_busy, 0);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_start_latency();
        t_data_bits();
        t_restart();
        t_stop();
        t_switch_idle();
        t_switch_busy();
        t_recovery();
        t_mask();
        t_set_beats_clear();
        report();
    end

    initial begin
        repeat (200000) @(negedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

endmodule